// File: doc/BRIEF.md
# Asynchronous SRAM Read Controller with Bank Decode

This block is the read path of a memory controller for asynchronous static RAM. It takes a 32-bit access address from a simple request port and routes it to one of five memory banks. Four of the banks form a contiguous run whose per-bank size is set by a 4-bit code. The fifth bank has a fixed size and a fixed place and takes priority where the two regions meet. When the synchronous DRAM window is switched on, the upper half of the RAM area belongs to it. The block then reports that routing on a strobe and leaves the SRAM pins alone.

For addresses that land in a bank, the block drives registered active-low chip selects, one active-low output enable shared by all banks, and a registered address bus. Each read has a first data cycle, zero to three wait cycles and a final data cycle. The read data is taken on the final data cycle. A lone read is followed by one idle cycle with every pin released, so that a slow device can let go of the data bus. A chained run of reads keeps the pins driven and releases them only after the last read of the run.

Request protocol: a request is sampled only when the block is idle, or during the final data cycle of a read in progress. The second case applies only if the request carries the chain flag and maps to an SRAM bank. A requester keeps its request on the port until it is sampled.

Top module: `sram_rd_ctrl`

## Requirements
- R1: While reset is low and right after its release, all five chip selects and the output enable are high (inactive) and `req_ready`, `req_unmapped` and `sdram_sel` are low.
- R2: The size code n on `cfg_bank_size` gives each of banks 0 to 3 a size of 2^(13+n) bytes. Bank k (k = 0..3) covers the range starting at 0x40000000 + k·2^(13+n). A read there drives `ram_cs_n[k]` low, with every other select high.
- R3: The range 0x60000000 to 0x6FFFFFFF always selects bank 4 (`ram_cs_n[4]`) and overrides any low bank that would reach it. With code 15, `ram_cs_n[2]` and `ram_cs_n[3]` are never driven low, and 0x70000000 to 0x7FFFFFFF maps to no bank.
- R4: With `cfg_sdram_en` high, any address from 0x60000000 to 0x7FFFFFFF completes in the cycle it is presented while idle. In that cycle `req_ready` and `sdram_sel` are high and `req_unmapped` is low. No select or output enable goes low.
- R5: An address outside every bank, or outside 0x40000000 to 0x7FFFFFFF, that is not routed to SDRAM completes in the cycle it is presented while idle. In that cycle `req_ready` and `req_unmapped` are high, `sdram_sel` is low, and no pin is driven.
- R6: A read sampled in cycle t, with wait code W on `cfg_wait_states`, holds its chip select and `ram_oe_n` low from cycle t+1 through t+2+W. During that span `ram_addr` equals the sampled address.
- R7: `req_ready` is high for exactly one cycle per SRAM read, in cycle t+2+W. In that cycle `req_rdata` equals `ram_rdata`. In every other cycle `req_rdata` is zero.
- R8: A read not followed by a chained request releases every select and the output enable in cycle t+3+W. A new request can then be sampled from cycle t+4+W.
- R9: A request with `req_consec` high that maps to an SRAM bank and is present in the final data cycle is sampled there. In the next cycle its own select is low, every other select is high, and `ram_oe_n` stays low with no released cycle in between.
- R10: A request with `req_consec` low that is present during a final data cycle is not sampled there. The release cycle of R8 happens first, and the request is sampled in the idle cycle that follows.
- R11: At most one chip select is low at any time, and `ram_oe_n` is low exactly when one chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address of the read |
| req_consec | input | 1 | Request chains onto the read in progress |
| req_ready | output | 1 | Read finished (or routed away) this cycle |
| req_rdata | output | 32 | Read data, valid while `req_ready` is high for an SRAM read |
| req_unmapped | output | 1 | Request hit no bank and no SDRAM window |
| sdram_sel | output | 1 | Request routed to SDRAM |
| cfg_bank_size | input | 4 | Size code for banks 0 to 3 (2^(13+n) bytes) |
| cfg_wait_states | input | 2 | Wait cycles inserted between the two data cycles |
| cfg_sdram_en | input | 1 | SDRAM owns 0x60000000 and up |
| ram_cs_n | output | 5 | Active-low chip selects, one per bank |
| ram_oe_n | output | 1 | Active-low output enable, shared |
| ram_addr | output | 32 | Registered address to the memories |
| ram_rdata | input | 32 | Data bus from the memories |

## Verification
The case that needs care is a read finishing in the same cycle that a chained read is sampled. In that one cycle, `req_ready` pulses for the old read and the select moves to the new bank, while the output enable must not rise. The bench provokes this with a three-read run: its middle read goes to a different bank from the first, and its last read goes to the same bank as the middle one. At each handover the bench checks the data, the single ready pulse, the new select and the output enable still low. It also checks that exactly one released cycle follows the end of the run, and that a request without the chain flag, presented at the same point, waits for that released cycle.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

  localparam int unsigned N_LOW  = 4;
  localparam int unsigned N_BANK = N_LOW + 1;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_FIRST = 3'd1,
    SEQ_HOLD  = 3'd2,
    SEQ_LAST  = 3'd3,
    SEQ_LEAD  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic [N_BANK-1:0] hit;
    logic              sdram;
    logic              unmapped;
  } route_t;

  // log2 of the low-bank size: smallest bank shifted by the size code
  function automatic int unsigned span_log2(int unsigned min_log2, int unsigned code);
    return min_log2 + code;
  endfunction

  // offset of low bank idx from the start of the RAM area
  function automatic logic [32:0] low_start(int unsigned idx, int unsigned lg);
    return 33'(idx) << lg;
  endfunction

endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode
  import sram_rd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned MIN_LOG2  = 13,
  parameter int unsigned AREA_LOG2 = 30,
  parameter int unsigned HI_LOG2   = 28,
  parameter logic [ADDR_W-1:0] AREA_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] HI_BASE   = 32'h6000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              sdram_en,
  output route_t            route
);

  localparam int unsigned SH_W = $clog2(ADDR_W) + 1;
  localparam logic [ADDR_W-1:0] HI_OFFSET = HI_BASE - AREA_BASE;

  logic              in_area;
  logic              upper_half;
  logic              hi_hit;
  logic              sd_over;
  logic [ADDR_W-1:0] offset;
  logic [SH_W-1:0]   shift;
  logic [ADDR_W-1:0] idx;
  logic [N_LOW-1:0]  low_hit;
  logic              top_hit;

  assign in_area    = (addr >> AREA_LOG2) == (AREA_BASE >> AREA_LOG2);
  assign upper_half = in_area && (addr >= HI_BASE);
  assign hi_hit     = (addr >> HI_LOG2) == (HI_BASE >> HI_LOG2);
  assign sd_over    = sdram_en && upper_half;
  assign offset     = addr - AREA_BASE;
  assign shift      = SH_W'(span_log2(MIN_LOG2, 32'(size_code)));
  assign idx        = offset >> shift;

  for (genvar gi = 0; gi < N_LOW; gi++) begin : g_low
    logic [ADDR_W:0] start_off;
    logic            shadowed;
    assign start_off = (ADDR_W+1)'(low_start(gi, 32'(shift)));
    // a low bank that starts inside the fixed bank is hidden by it
    assign shadowed  = start_off >= {1'b0, HI_OFFSET};
    assign low_hit[gi] = in_area && !sd_over && !hi_hit && !shadowed &&
                         (idx == ADDR_W'(gi));
  end

  assign top_hit        = in_area && !sd_over && hi_hit;
  assign route.hit      = {top_hit, low_hit};
  assign route.sdram    = sd_over;
  assign route.unmapped = !sd_over && !(|route.hit);

endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq
  import sram_rd_pkg::*;
#(
  parameter int unsigned WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_consec,
  input  logic              is_sram,
  input  logic              is_other,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              start,
  output logic              last_beat,
  output logic              take_next,
  output logic              quick_done,
  output logic              release_pins
);

  seq_state_e        st_q, st_d;
  logic [WAIT_W-1:0] wcnt_q;
  logic              idle_take;
  logic              is_idle;

  assign is_idle      = (st_q == SEQ_IDLE);
  assign last_beat    = (st_q == SEQ_LAST);
  assign idle_take    = is_idle && req_valid && is_sram;
  assign quick_done   = is_idle && req_valid && is_other;
  assign take_next    = last_beat && req_valid && req_consec && is_sram;
  assign start        = idle_take || take_next;
  assign release_pins = last_beat && !take_next;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE:  if (idle_take) st_d = SEQ_FIRST;
      SEQ_FIRST: st_d = (wcnt_q == '0) ? SEQ_LAST : SEQ_HOLD;
      SEQ_HOLD:  if (wcnt_q == WAIT_W'(1)) st_d = SEQ_LAST;
      SEQ_LAST:  st_d = take_next ? SEQ_FIRST : SEQ_LEAD;
      SEQ_LEAD:  st_d = SEQ_IDLE;
      default:   st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        wcnt_q <= cfg_wait;
      end else if (st_q == SEQ_HOLD) begin
        wcnt_q <= wcnt_q - WAIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv #(
  parameter int unsigned N_BANK = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              release_pins,
  input  logic [N_BANK-1:0] sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [N_BANK-1:0] cs_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n     <= '1;
      oe_n     <= 1'b1;
      addr_out <= '0;
    end else if (load) begin
      cs_n     <= ~sel;
      oe_n     <= 1'b0;
      addr_out <= addr_in;
    end else if (release_pins) begin
      cs_n     <= '1;
      oe_n     <= 1'b1;
    end
  end

endmodule

// File: rtl/sram_rd_ctrl.sv
module sram_rd_ctrl
  import sram_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SIZE_W   = 4,
  parameter int unsigned WAIT_W   = 2,
  parameter int unsigned MIN_LOG2 = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_consec,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  output logic              req_unmapped,
  output logic              sdram_sel,
  input  logic [SIZE_W-1:0] cfg_bank_size,
  input  logic [WAIT_W-1:0] cfg_wait_states,
  input  logic              cfg_sdram_en,
  output logic [N_BANK-1:0] ram_cs_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_rdata
);

  route_t route;
  logic   route_sram;
  logic   route_other;

  // named internal events, observed by the bound checker
  logic   evt_start;
  logic   evt_last;
  logic   evt_chain;
  logic   evt_quick;
  logic   evt_release;
  logic   evt_top_start;

  sram_bank_decode #(
    .ADDR_W   (ADDR_W),
    .SIZE_W   (SIZE_W),
    .MIN_LOG2 (MIN_LOG2)
  ) u_decode (
    .addr      (req_addr),
    .size_code (cfg_bank_size),
    .sdram_en  (cfg_sdram_en),
    .route     (route)
  );

  assign route_sram  = |route.hit;
  assign route_other = route.sdram || route.unmapped;

  sram_rd_seq #(
    .WAIT_W (WAIT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_consec   (req_consec),
    .is_sram      (route_sram),
    .is_other     (route_other),
    .cfg_wait     (cfg_wait_states),
    .start        (evt_start),
    .last_beat    (evt_last),
    .take_next    (evt_chain),
    .quick_done   (evt_quick),
    .release_pins (evt_release)
  );

  sram_pin_drv #(
    .N_BANK (N_BANK),
    .ADDR_W (ADDR_W)
  ) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (evt_start),
    .release_pins (evt_release),
    .sel          (route.hit),
    .addr_in      (req_addr),
    .cs_n         (ram_cs_n),
    .oe_n         (ram_oe_n),
    .addr_out     (ram_addr)
  );

  assign evt_top_start = evt_start && route.hit[N_BANK-1];

  assign req_ready    = evt_last || evt_quick;
  assign req_unmapped = evt_quick && route.unmapped;
  assign sdram_sel    = evt_quick && route.sdram;
  assign req_rdata    = evt_last ? ram_rdata : '0;

endmodule

// File: rtl/sram_rd_ctrl_chk.sv
module sram_rd_ctrl_chk #(
  parameter int unsigned N_BANK = 5,
  parameter int unsigned SIZE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_BANK-1:0] ram_cs_n,
  input logic              ram_oe_n,
  input logic              req_ready,
  input logic              req_unmapped,
  input logic              sdram_sel,
  input logic [SIZE_W-1:0] cfg_bank_size,
  input logic              evt_start,
  input logic              evt_last,
  input logic              evt_chain,
  input logic              evt_top_start
);

  assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ram_cs_n) <= 1);

  assert_oe_tracks_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe_n == (&ram_cs_n));

  assert_single_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last |=> !req_ready);

  assert_lead_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last && !evt_chain) |=> ((&ram_cs_n) && ram_oe_n));

  assert_chain_keeps_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_chain |=> !ram_oe_n);

  assert_top_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_top_start |=> !ram_cs_n[N_BANK-1]);

  assert_overlap_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start && (cfg_bank_size == '1)) |=> (ram_cs_n[3:2] == 2'b11));

  assert_sdram_no_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_sel |=> ((&ram_cs_n) && ram_oe_n));

  assert_sdram_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_sel |-> (req_ready && !req_unmapped));

  assert_unmapped_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_unmapped |-> (req_ready && !sdram_sel));

endmodule

bind sram_rd_ctrl sram_rd_ctrl_chk #(
  .N_BANK (sram_rd_pkg::N_BANK),
  .SIZE_W (SIZE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ram_cs_n      (ram_cs_n),
  .ram_oe_n      (ram_oe_n),
  .req_ready     (req_ready),
  .req_unmapped  (req_unmapped),
  .sdram_sel     (sdram_sel),
  .cfg_bank_size (cfg_bank_size),
  .evt_start     (evt_start),
  .evt_last      (evt_last),
  .evt_chain     (evt_chain),
  .evt_top_start (evt_top_start)
);

// File: tb/sram_rd_ctrl_tb.sv
module sram_rd_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_consec = 1'b0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        req_unmapped;
  logic        sdram_sel;
  logic [3:0]  cfg_bank_size = '0;
  logic [1:0]  cfg_wait_states = '0;
  logic        cfg_sdram_en = 1'b0;
  logic [4:0]  ram_cs_n;
  logic        ram_oe_n;
  logic [31:0] ram_addr;
  logic [31:0] ram_rdata = 32'hDEAD_BEEF;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sram_rd_ctrl u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_consec      (req_consec),
    .req_ready       (req_ready),
    .req_rdata       (req_rdata),
    .req_unmapped    (req_unmapped),
    .sdram_sel       (sdram_sel),
    .cfg_bank_size   (cfg_bank_size),
    .cfg_wait_states (cfg_wait_states),
    .cfg_sdram_en    (cfg_sdram_en),
    .ram_cs_n        (ram_cs_n),
    .ram_oe_n        (ram_oe_n),
    .ram_addr        (ram_addr),
    .ram_rdata       (ram_rdata)
  );

  // vector: addr[43:12] size[11:8] sdram_en[7] wait[6:5] kind[4:3] bank[2:0]
  // kind 0 = SRAM bank, 1 = SDRAM, 2 = unmapped
  localparam int NV = 19;
  localparam logic [43:0] VEC [NV] = '{
    {32'h4000_0000, 4'd0,  1'b0, 2'd0, 2'd0, 3'd0},
    {32'h4000_2000, 4'd0,  1'b0, 2'd1, 2'd0, 3'd1},
    {32'h4000_7FFC, 4'd0,  1'b0, 2'd2, 2'd0, 3'd3},
    {32'h4000_8000, 4'd0,  1'b0, 2'd0, 2'd2, 3'd0},
    {32'h4000_0000, 4'd15, 1'b0, 2'd3, 2'd0, 3'd0},
    {32'h5FFF_FFFC, 4'd15, 1'b0, 2'd0, 2'd0, 3'd1},
    {32'h6000_0000, 4'd15, 1'b0, 2'd1, 2'd0, 3'd4},
    {32'h7000_0000, 4'd15, 1'b0, 2'd0, 2'd2, 3'd0},
    {32'h5800_0000, 4'd14, 1'b0, 2'd2, 2'd0, 3'd3},
    {32'h6FFF_FFFC, 4'd14, 1'b0, 2'd0, 2'd0, 3'd4},
    {32'h7000_0000, 4'd14, 1'b0, 2'd0, 2'd2, 3'd0},
    {32'h6000_0000, 4'd14, 1'b1, 2'd0, 2'd1, 3'd0},
    {32'h7FFF_FFFC, 4'd3,  1'b1, 2'd0, 2'd1, 3'd0},
    {32'h5FFF_FFFC, 4'd14, 1'b1, 2'd1, 2'd0, 3'd3},
    {32'h3FFF_FFFC, 4'd15, 1'b0, 2'd0, 2'd2, 3'd0},
    {32'h8000_0000, 4'd15, 1'b1, 2'd0, 2'd2, 3'd0},
    {32'h4C00_0000, 4'd13, 1'b0, 2'd0, 2'd0, 3'd3},
    {32'h5000_0000, 4'd13, 1'b0, 2'd0, 2'd2, 3'd0},
    {32'h4030_0000, 4'd7,  1'b0, 2'd3, 2'd0, 3'd3}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] sel_of(input int bank);
    return ~(5'b00001 << bank);
  endfunction

  task automatic pins_idle(input string req, input string what);
    check(ram_cs_n == 5'h1F && ram_oe_n == 1'b1, req, what,
          {58'd0, ram_cs_n, ram_oe_n}, {58'd0, 5'h1F, 1'b1});
  endtask

  task automatic pins_on(input string req, input string what, input int bank);
    check(ram_cs_n == sel_of(bank) && ram_oe_n == 1'b0, req, what,
          {58'd0, ram_cs_n, ram_oe_n}, {58'd0, sel_of(bank), 1'b0});
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    pins_idle("R1", "pins during reset");
    check(!req_ready && !req_unmapped && !sdram_sel, "R1", "strobes during reset",
          {61'd0, req_ready, req_unmapped, sdram_sel}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    pins_idle("R1", "pins after reset release");

    // table walk: one isolated request per vector
    for (int v = 0; v < NV; v++) begin
      logic [31:0] a;
      logic [1:0]  w;
      logic [1:0]  kind;
      int          bank;
      string       rq;
      logic [31:0] dv;
      a    = VEC[v][43:12];
      w    = VEC[v][6:5];
      kind = VEC[v][4:3];
      bank = int'(VEC[v][2:0]);
      rq   = (bank == 4) ? "R3" : "R2";
      dv   = {a[15:0], 16'hC0DE} ^ 32'(v);

      @(negedge clk);
      cfg_bank_size   = VEC[v][11:8];
      cfg_sdram_en    = VEC[v][7];
      cfg_wait_states = w;
      req_valid  = 1'b1;
      req_addr   = a;
      req_consec = 1'b0;
      ram_rdata  = 32'hDEAD_BEEF;
      #2;
      if (kind == 2'd1) begin
        check(req_ready && sdram_sel && !req_unmapped, "R4", $sformatf("sdram route v%0d", v),
              {61'd0, req_ready, sdram_sel, req_unmapped}, {61'd0, 3'b110});
      end else if (kind == 2'd2) begin
        check(req_ready && req_unmapped && !sdram_sel, "R5", $sformatf("unmapped v%0d", v),
              {61'd0, req_ready, sdram_sel, req_unmapped}, {61'd0, 3'b101});
      end else begin
        check(!req_ready, "R6", $sformatf("no ready at sample v%0d", v),
              {63'd0, req_ready}, 64'd0);
      end

      @(negedge clk);
      req_valid = 1'b0;
      #2;
      if (kind != 2'd0) begin
        pins_idle((kind == 2'd1) ? "R4" : "R5", $sformatf("no pins v%0d", v));
      end else begin
        pins_on(rq, $sformatf("select v%0d", v), bank);
        check(ram_addr == a, "R6", $sformatf("address v%0d", v),
              {32'd0, ram_addr}, {32'd0, a});
        for (int c = 0; c < int'(w); c++) begin
          @(negedge clk);
          #2;
          pins_on("R6", $sformatf("wait cycle %0d v%0d", c, v), bank);
          check(!req_ready, "R7", $sformatf("no early ready v%0d", v),
                {63'd0, req_ready}, 64'd0);
        end
        @(negedge clk);
        ram_rdata = dv;
        #2;
        pins_on("R6", $sformatf("last data cycle v%0d", v), bank);
        check(req_ready && req_rdata == dv, "R7", $sformatf("data v%0d", v),
              {31'd0, req_ready, req_rdata}, {31'd0, 1'b1, dv});
        @(negedge clk);
        ram_rdata = 32'hDEAD_BEEF;
        #2;
        pins_idle("R8", $sformatf("lead-out v%0d", v));
        check(!req_ready && req_rdata == 32'd0, "R7", $sformatf("quiet after data v%0d", v),
              {31'd0, req_ready, req_rdata}, 64'd0);
      end
    end

    // chained run: A (bank 0), B (bank 1), C (bank 1), size 15, one wait
    @(negedge clk);
    cfg_bank_size   = 4'd15;
    cfg_sdram_en    = 1'b0;
    cfg_wait_states = 2'd1;
    req_valid  = 1'b1;
    req_addr   = 32'h4000_0010;
    req_consec = 1'b0;
    @(negedge clk);                       // A first data cycle
    req_valid = 1'b0;
    #2;
    pins_on("R9", "chain A first", 0);
    @(negedge clk);                       // A wait
    @(negedge clk);                       // A last, B offered with chain flag
    ram_rdata  = 32'h1111_AAAA;
    req_valid  = 1'b1;
    req_addr   = 32'h5000_0020;
    req_consec = 1'b1;
    #2;
    check(req_ready && req_rdata == 32'h1111_AAAA, "R7", "chain A data",
          {31'd0, req_ready, req_rdata}, {31'd0, 1'b1, 32'h1111_AAAA});
    @(negedge clk);                       // B first
    req_valid = 1'b0;
    ram_rdata = 32'hDEAD_BEEF;
    #2;
    pins_on("R9", "chain B select without release", 1);
    check(ram_addr == 32'h5000_0020, "R9", "chain B address",
          {32'd0, ram_addr}, {32'd0, 32'h5000_0020});
    check(!req_ready, "R7", "single ready after A", {63'd0, req_ready}, 64'd0);
    @(negedge clk);                       // B wait
    @(negedge clk);                       // B last, C offered
    ram_rdata  = 32'h2222_BBBB;
    req_valid  = 1'b1;
    req_addr   = 32'h5000_0040;
    req_consec = 1'b1;
    #2;
    check(req_ready && req_rdata == 32'h2222_BBBB, "R7", "chain B data",
          {31'd0, req_ready, req_rdata}, {31'd0, 1'b1, 32'h2222_BBBB});
    @(negedge clk);                       // C first
    req_valid  = 1'b0;
    req_consec = 1'b0;
    ram_rdata  = 32'hDEAD_BEEF;
    #2;
    pins_on("R9", "chain C same bank held", 1);
    @(negedge clk);                       // C wait
    @(negedge clk);                       // C last, run ends
    ram_rdata = 32'h3333_CCCC;
    #2;
    check(req_ready && req_rdata == 32'h3333_CCCC, "R7", "chain C data",
          {31'd0, req_ready, req_rdata}, {31'd0, 1'b1, 32'h3333_CCCC});
    @(negedge clk);
    ram_rdata = 32'hDEAD_BEEF;
    #2;
    pins_idle("R8", "single lead-out after run");

    // R10: unchained request offered in a last data cycle waits for idle
    cfg_wait_states = 2'd0;
    @(negedge clk);                       // idle: take E (bank 0)
    req_valid  = 1'b1;
    req_addr   = 32'h4000_0100;
    req_consec = 1'b0;
    @(negedge clk);                       // E first
    req_valid = 1'b0;
    @(negedge clk);                       // E last, F offered unchained
    req_valid = 1'b1;
    req_addr  = 32'h5000_0100;
    #2;
    check(req_ready, "R10", "E ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk);                       // release cycle, F still held
    #2;
    pins_idle("R10", "unchained request not taken in last cycle");
    @(negedge clk);                       // idle: F sampled
    #2;
    pins_idle("R10", "idle cycle before F");
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    pins_on("R10", "F taken from idle", 1);
    @(negedge clk);                       // F last
    #2;
    check(req_ready, "R10", "F ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    #2;
    pins_idle("R8", "F lead-out");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule